// File: doc/BRIEF.md
# Polyphase Apparent Power Combiner

This block builds one signed total apparent power figure from three phases of a metering front end. Each phase supplies an unsigned RMS voltage magnitude, an unsigned RMS current magnitude and a 12-bit two's-complement gain trim. A configuration byte chooses which voltage feeds each phase product and which phase terms enter the sum. The choice of voltage suits meters wired in different ways: in one wiring the middle phase has no voltage sense of its own and must borrow one.

A one-cycle `in_valid_i` strobe captures all inputs. The block runs them through a three-stage pipeline: the voltage choice and the products, then the gain scaling with term clamping and masking, then the sum with saturation. It returns the result with a one-cycle `out_valid_o` pulse. The RMS values are taken as already offset-corrected, and the block adds no offset of its own. `total_o` keeps its value between results.

Top module: `apparent_power_combiner`

## Requirements
- R1: With mode code 0 in `cfg_i[7:6]`, the total is VA·IA + VB·IB + VC·IC, before gain and masking.
- R2: With mode code 1, the phase B voltage is (VA+VC)>>1. The sum is taken at full width, and the shift truncates toward minus infinity.
- R3: With mode code 2, the phase B term uses VA in place of VB.
- R4: Mode code 3 gives exactly the result of mode code 0.
- R5: `cfg_i[0]`, `cfg_i[1]` and `cfg_i[2]` include the A, B and C terms respectively when 1, and drop the term when 0. With all three at 0 the total is 0.
- R6: Each product p is scaled to floor(p·(4096+G)/4096), where G is that phase's gain field read as two's complement. Phase A is in `gain_i[11:0]`, B in `gain_i[23:12]` and C in `gain_i[35:24]`.
- R7: Gain code 0x800 halves the term (floor), 0x000 leaves it unchanged, and 0x7FF gives floor(p·6143/4096).
- R8: Each scaled term clamps at 2^TERM_W−1.
- R9: The sum saturates at 2^(OUT_W−1)−1, and the total is never negative.
- R10: `out_valid_o` pulses for one cycle exactly three clock edges after the edge that samples `in_valid_i`. It does not pulse otherwise, and `total_o` holds while `out_valid_o` is low.
- R11: Inputs are sampled only at the `in_valid_i` edge, and later changes do not alter that result. `cfg_i[5:3]` has no effect.
- R12: After reset, `out_valid_o` is 0 and `total_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Start strobe, captures all inputs |
| cfg_i | input | 8 | [7:6] mode code, [2:0] phase selects C,B,A |
| v_rms_i | input | 3*V_W | RMS voltages, A in the low slice |
| i_rms_i | input | 3*V_W | RMS currents, A in the low slice |
| gain_i | input | 36 | Per-phase gain trims, A in the low slice |
| out_valid_o | output | 1 | Result pulse |
| total_o | output | OUT_W | Signed total apparent power |

## Verification
The bench builds the block with V_W=3, TERM_W=6 and OUT_W=7. With these widths, a full-scale product of 49 scaled by up to 1.5 overruns the 6-bit term clamp, and three clamped terms overrun the 7-bit signed output. Both saturation paths are therefore reached often. The narrow voltage width lets the bench sweep every VA/VC pair against every phase B current in the averaging mode. It also sweeps all 4096 gain codes on a single phase, and it runs randomized operands across every mode and select combination.

// File: rtl/apc_pkg.sv
package apc_pkg;
  localparam int NUM_PH  = 3;
  localparam int GAIN_W  = 12;
  localparam int LAT     = 3;
  localparam int MODE_HI = 7;
  localparam int MODE_LO = 6;

  typedef enum logic [1:0] {
    MODE_OWN   = 2'd0,
    MODE_AVG_B = 2'd1,
    MODE_A_B   = 2'd2,
    MODE_RSVD  = 2'd3
  } apc_mode_e;
endpackage

// File: rtl/apc_vsel.sv
module apc_vsel
  import apc_pkg::*;
#(
  parameter int V_W = 12
) (
  input  logic [1:0]            mode_i,
  input  logic [NUM_PH*V_W-1:0] v_i,
  output logic [NUM_PH*V_W-1:0] v_o
);
  logic [V_W-1:0] va, vb, vc, vb_eff;
  logic [V_W:0]   ac_sum;

  assign va = v_i[0*V_W +: V_W];
  assign vb = v_i[1*V_W +: V_W];
  assign vc = v_i[2*V_W +: V_W];
  assign ac_sum = {1'b0, va} + {1'b0, vc};

  always_comb begin
    unique case (apc_mode_e'(mode_i))
      MODE_AVG_B: vb_eff = ac_sum[V_W:1];
      MODE_A_B:   vb_eff = va;
      default:    vb_eff = vb;  // own and reserved
    endcase
  end

  assign v_o = {vc, vb_eff, va};
endmodule

// File: rtl/apc_term.sv
module apc_term
  import apc_pkg::*;
#(
  parameter int V_W    = 12,
  parameter int TERM_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [V_W-1:0]    v_i,
  input  logic [V_W-1:0]    i_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              en_i,
  output logic [TERM_W-1:0] term_o
);
  localparam int PW  = 2 * V_W;
  localparam int FW  = GAIN_W + 1;
  localparam int XW  = PW + FW;
  localparam int SW  = XW - GAIN_W;
  localparam int CW  = ((SW > TERM_W) ? SW : TERM_W) + 1;
  localparam logic [CW-1:0] TERM_MAX = (CW'(1) << TERM_W) - CW'(1);

  logic [PW-1:0]     prod_q;
  logic [FW-1:0]     fac_q;
  logic              en_q;
  logic [FW-1:0]     fac_d;
  logic [XW-1:0]     wide;
  logic [SW-1:0]     scaled;

  // 4096 + G, always in [2048, 6143]
  assign fac_d = (FW'(1) << GAIN_W) + {gain_i[GAIN_W-1], gain_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      fac_q  <= '0;
      en_q   <= 1'b0;
    end else begin
      prod_q <= PW'(v_i) * PW'(i_i);
      fac_q  <= fac_d;
      en_q   <= en_i;
    end
  end

  assign wide   = XW'(prod_q) * XW'(fac_q);
  assign scaled = wide[XW-1:GAIN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_o <= '0;
    end else if (!en_q) begin
      term_o <= '0;
    end else if (CW'(scaled) > TERM_MAX) begin
      term_o <= TERM_MAX[TERM_W-1:0];
    end else begin
      term_o <= scaled[TERM_W-1:0];
    end
  end
endmodule

// File: rtl/apc_sum.sv
module apc_sum
  import apc_pkg::*;
#(
  parameter int TERM_W = 24,
  parameter int OUT_W  = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [NUM_PH*TERM_W-1:0] terms_i,
  output logic signed [OUT_W-1:0]  total_o
);
  localparam int AW = TERM_W + 2;
  localparam int CW = ((AW > OUT_W) ? AW : OUT_W) + 1;
  localparam logic [CW-1:0] OUT_MAX = (CW'(1) << (OUT_W - 1)) - CW'(1);

  logic [AW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int p = 0; p < NUM_PH; p++) begin
      acc = acc + AW'(terms_i[p*TERM_W +: TERM_W]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_o <= '0;
    end else if (valid_i) begin
      if (CW'(acc) > OUT_MAX) total_o <= OUT_MAX[OUT_W-1:0];
      else                    total_o <= OUT_W'(acc);
    end
  end
endmodule

// File: rtl/apparent_power_combiner.sv
module apparent_power_combiner
  import apc_pkg::*;
#(
  parameter int V_W    = 12,
  parameter int TERM_W = 24,
  parameter int OUT_W  = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  input  logic [7:0]                cfg_i,
  input  logic [NUM_PH*V_W-1:0]     v_rms_i,
  input  logic [NUM_PH*V_W-1:0]     i_rms_i,
  input  logic [NUM_PH*GAIN_W-1:0]  gain_i,
  output logic                      out_valid_o,
  output logic signed [OUT_W-1:0]   total_o
);
  logic [LAT-1:0]             vld_q;
  logic [NUM_PH*V_W-1:0]      v_eff;
  logic [NUM_PH*TERM_W-1:0]   terms;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], in_valid_i};
  end

  apc_vsel #(.V_W(V_W)) u_vsel (
    .mode_i (cfg_i[MODE_HI:MODE_LO]),
    .v_i    (v_rms_i),
    .v_o    (v_eff)
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    apc_term #(.V_W(V_W), .TERM_W(TERM_W)) u_term (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .v_i    (v_eff[p*V_W +: V_W]),
      .i_i    (i_rms_i[p*V_W +: V_W]),
      .gain_i (gain_i[p*GAIN_W +: GAIN_W]),
      .en_i   (cfg_i[p]),
      .term_o (terms[p*TERM_W +: TERM_W])
    );
  end

  apc_sum #(.TERM_W(TERM_W), .OUT_W(OUT_W)) u_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (vld_q[LAT-2]),
    .terms_i (terms),
    .total_o (total_o)
  );

  assign out_valid_o = vld_q[LAT-1];
endmodule

// File: rtl/apc_checker.sv
module apc_checker
  import apc_pkg::*;
#(
  parameter int OUT_W = 24
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic [7:0]              cfg_i,
  input logic                    out_valid_o,
  input logic signed [OUT_W-1:0] total_o
);
  a_r10_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##3 out_valid_o);

  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i, 3));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(total_o));

  a_r9_nonneg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !total_o[OUT_W-1]);

  a_r5_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(in_valid_i, 3) && ($past(cfg_i[2:0], 3) == 3'b000))
      |-> (total_o == '0));
endmodule

bind apparent_power_combiner apc_checker #(.OUT_W(OUT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .cfg_i       (cfg_i),
  .out_valid_o (out_valid_o),
  .total_o     (total_o)
);

// File: tb/apparent_power_combiner_tb.sv
module apparent_power_combiner_tb;
  localparam int V_W    = 3;
  localparam int TERM_W = 6;
  localparam int OUT_W  = 7;
  localparam int GW     = 12;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [7:0]         cfg = '0;
  logic [3*V_W-1:0]   v_rms = '0;
  logic [3*V_W-1:0]   i_rms = '0;
  logic [3*GW-1:0]    gain = '0;
  logic               out_valid;
  logic signed [OUT_W-1:0] total;

  int total_checks = 0;
  int bad_checks = 0;
  int seed = 32'h1234_5678;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  apparent_power_combiner #(.V_W(V_W), .TERM_W(TERM_W), .OUT_W(OUT_W)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .in_valid_i (in_valid), .cfg_i (cfg),
    .v_rms_i (v_rms), .i_rms_i (i_rms), .gain_i (gain),
    .out_valid_o (out_valid), .total_o (total)
  );

  function automatic int rnd(input int m);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 32'h7fff) % m;
  endfunction

  function automatic int term_ref(input int v, input int i, input int g, input bit en);
    int gs, t;
    if (!en) return 0;
    gs = (g >= 2048) ? g - 4096 : g;
    t = ((v * i) * (4096 + gs)) / 4096;  // non-negative, so floor
    if (t > (1 << TERM_W) - 1) t = (1 << TERM_W) - 1;
    return t;
  endfunction

  function automatic int total_ref(input int mode, input int sel,
                                   input int va, input int vb, input int vc,
                                   input int ia, input int ib, input int ic,
                                   input int ga, input int gb, input int gc);
    int vbe, s;
    case (mode)
      1: vbe = (va + vc) >> 1;
      2: vbe = va;
      default: vbe = vb;
    endcase
    s = term_ref(va, ia, ga, sel[0]) + term_ref(vbe, ib, gb, sel[1])
      + term_ref(vc, ic, gc, sel[2]);
    if (s > (1 << (OUT_W - 1)) - 1) s = (1 << (OUT_W - 1)) - 1;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total_checks++;
    if (!ok) begin
      bad_checks++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic scramble();
    cfg   = 8'(rnd(256));
    v_rms = 9'(rnd(512));
    i_rms = 9'(rnd(512));
    gain  = {12'(rnd(4096)), 12'(rnd(4096)), 12'(rnd(4096))};
  endtask

  task automatic run_vec(input int mode, input int sel,
                         input int va, input int vb, input int vc,
                         input int ia, input int ib, input int ic,
                         input int ga, input int gb, input int gc,
                         input string req);
    int exp, held;
    exp = total_ref(mode, sel, va, vb, vc, ia, ib, ic, ga, gb, gc);
    cfg   = {2'(mode), 3'(rnd(8)), 3'(sel)};  // R11 junk in [5:3]
    v_rms = {3'(vc), 3'(vb), 3'(va)};
    i_rms = {3'(ic), 3'(ib), 3'(ia)};
    gain  = {12'(gc), 12'(gb), 12'(ga)};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    scramble();  // R11 later changes ignored
    check(out_valid == 1'b0, "R10 early", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 early", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R10 pulse", int'(out_valid), 1);
    check(int'(total) == exp, req, int'(total), exp);
    held = int'(total);
    @(negedge clk);
    check(out_valid == 1'b0 && int'(total) == held, "R10 hold", int'(total), held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad_checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R12 valid", int'(out_valid), 0);
    check(total == '0, "R12 total", int'(total), 0);

    // R7 gain corners, p = 16
    run_vec(0, 1, 4, 0, 0, 4, 0, 0, 12'h800, 0, 0, "R7 half");
    run_vec(0, 1, 4, 0, 0, 4, 0, 0, 12'h000, 0, 0, "R7 unity");
    run_vec(0, 1, 4, 0, 0, 4, 0, 0, 12'h7FF, 0, 0, "R7 max");
    // R8 term clamp: 49*1.5 -> 63
    run_vec(0, 4, 0, 0, 7, 0, 0, 7, 0, 0, 12'h7FF, "R8 clamp");
    // R9 full saturation
    run_vec(0, 7, 7, 7, 7, 7, 7, 7, 12'h7FF, 12'h7FF, 12'h7FF, "R9 sat");
    // R5 all off
    run_vec(0, 0, 7, 7, 7, 7, 7, 7, 0, 0, 0, "R5 none");

    // R2 exhaustive half-sum on phase B only
    for (int va = 0; va < 8; va++)
      for (int vc = 0; vc < 8; vc++)
        for (int ib = 0; ib < 8; ib++)
          run_vec(1, 2, va, rnd(8), vc, rnd(8), ib, rnd(8), 0, 0, 0, "R2 avg");

    // R6 every gain code on one phase
    for (int g = 0; g < 4096; g++)
      run_vec(0, 1, 5, 0, 0, 7, 0, 0, g, 0, 0, "R6 gain");

    // R1 R3 R4 R5 all modes and selects, random operands
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 8; s++)
        for (int k = 0; k < 12; k++)
          run_vec(m, s, rnd(8), rnd(8), rnd(8), rnd(8), rnd(8), rnd(8),
                  rnd(4096), rnd(4096), rnd(4096),
                  (m == 0) ? "R1 R5 mode0" : (m == 1) ? "R2 R5 mode1" :
                  (m == 2) ? "R3 R5 mode2" : "R4 R5 mode3");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end
endmodule